// File: doc/BRIEF.md
# ADC conversion and calibration sequencer

This block is the digital timing core of a self-calibrating successive-approximation converter. It runs from one master clock and derives an internal tick on every fourth master edge. It moves between three phases: calibration, conversion, and acquisition/track. It raises an end-of-conversion flag while busy and an end-of-track flag while the input is still settling. During conversion it emits a one-cycle step strobe on each internal tick. An external analog model uses that strobe to resolve one bit per step.

A conversion is requested by driving the active-low hold input low. The request is honoured only on an internal tick, so an unsynchronised request waits up to four master cycles. The conversion length follows the resolution parameter. After each conversion the end-of-track flag marks a fixed 15-cycle acquisition window. In loopback mode the block takes its own end-of-track flag as the hold request and free-runs at a fixed sample period. Reset overrides everything: it clears the block at any moment, and its release always starts a full calibration.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst` is high (asynchronous, active high, even mid-conversion) the outputs are eoc_o=1, cal_busy_o=1, eot_o=0, step_o=0.
- R2: After `rst` falls, calibration lasts CAL_CYCLES master edges: eoc_o and cal_busy_o are 1 through edge CAL_CYCLES-1 and fall at edge CAL_CYCLES. The first master edge with rst low is edge 1.
- R3: Hold requests made while cal_busy_o is 1 are ignored: no step pulse occurs, and calibration ends into acquisition, not conversion.
- R4: The internal tick occurs at every master edge k after reset release with k a multiple of 4. A conversion starts only at a tick, so eoc_o rises 1 to 4 cycles after hold is seen low.
- R5: eoc_o stays high for exactly 48+N master cycles per conversion, with N=4*(RES_BITS-12). Counting the synchronising cycle, the time from hold fall to eoc_o fall is at least 49+N cycles.
- R6: step_o is a single-cycle pulse on each tick while converting, RES_BITS pulses per conversion, the first one 3 cycles after eoc_o rises.
- R7: eot_o rises on the edge where eoc_o falls (after conversion or calibration) and falls 15 cycles later, unless a new conversion starts first. eoc_o and eot_o are never both 1.
- R8: A hold low pulse that ends between ticks is remembered and starts a conversion at the next tick, provided the block is in acquisition or track.
- R9: If hold is still low at a tick after a conversion ends, a new conversion starts at once, even inside the acquisition window.
- R10: With loop_en_i=1 the hold request is taken from eot_o, so once running, conversions start every 64+N master cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Asynchronous active-high reset; release starts calibration |
| hold_n_i | input | 1 | Active-low hold / conversion request |
| loop_en_i | input | 1 | 1: take hold request from eot_o instead of hold_n_i |
| eoc_o | output | 1 | High while converting or calibrating |
| eot_o | output | 1 | High during the post-conversion acquisition window |
| step_o | output | 1 | One-cycle bit-step strobe on internal ticks during conversion |
| cal_busy_o | output | 1 | High while calibration runs |

## Verification
A wrong phase shows up on the flags almost at once. A conversion that starts on a non-tick edge moves the rise of eoc_o by up to three cycles. A miscounted conversion moves the fall of eoc_o and changes the number of step pulses seen by that fall. A lost or extra acquisition state shifts the fall of eot_o, and in loopback it changes the sample period from the second sample on. A calibration that wrongly accepts hold shows step pulses or an early eoc_o fall within one tick of the request.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_CAL   = 2'd0,
      SEQ_ACQ   = 2'd1,
      SEQ_TRACK = 2'd2,
      SEQ_CONV  = 2'd3
   } seq_state_e;

   // cycles eoc stays high for one conversion
   function automatic int unsigned conv_high_cycles(input int unsigned res_bits,
                                                    input int unsigned base_cycles);
      return base_cycles - 1 + 4 * (res_bits - 12);
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
   parameter int unsigned DIV_LOG2 = 2
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   logic [DIV_LOG2-1:0] div_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) div_q <= '0;
      else     div_q <= div_q + DIV_LOG2'(1);
   end

   assign tick_o = &div_q;
endmodule

// File: rtl/adc_seq_hold.sv
module adc_seq_hold (
   input  logic clk,
   input  logic rst,
   input  logic hold_n_i,
   input  logic loop_en_i,
   input  logic eot_i,
   input  logic arm_i,
   input  logic tick_i,
   output logic req_o
);
   logic hold_eff;
   logic hold_q;
   logic fall_q;

   assign hold_eff = loop_en_i ? eot_i : hold_n_i;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         hold_q <= 1'b1;
         fall_q <= 1'b0;
      end else begin
         hold_q <= hold_eff;
         if (!arm_i || tick_i)
            fall_q <= 1'b0;
         else if (hold_q && !hold_eff)
            fall_q <= 1'b1;
      end
   end

   assign req_o = fall_q || !hold_eff;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned CAL_CYCLES = 58280,
   parameter int unsigned CONV_HI    = 48,
   parameter int unsigned ACQ_CYCLES = 15
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic req_i,
   output logic arm_o,
   output logic eoc_o,
   output logic eot_o,
   output logic cal_busy_o,
   output logic step_o
);
   localparam int unsigned CNT_MAX = max3(CAL_CYCLES, CONV_HI, ACQ_CYCLES);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CYCLES - 1);
   localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_HI - 1);
   localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             start;

   assign start = tick_i && req_i;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q + CNT_W'(1);
      unique case (state_q)
         SEQ_CAL: begin
            if (cnt_q == CAL_LAST) begin
               state_d = SEQ_ACQ;
               cnt_d   = '0;
            end
         end
         SEQ_ACQ: begin
            if (start) begin
               state_d = SEQ_CONV;
               cnt_d   = '0;
            end else if (cnt_q == ACQ_LAST) begin
               state_d = SEQ_TRACK;
               cnt_d   = '0;
            end
         end
         SEQ_TRACK: begin
            cnt_d = '0;
            if (start) state_d = SEQ_CONV;
         end
         SEQ_CONV: begin
            if (cnt_q == CONV_LAST) begin
               state_d = SEQ_ACQ;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = SEQ_CAL;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q <= SEQ_CAL;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign arm_o      = (state_q == SEQ_ACQ) || (state_q == SEQ_TRACK);
   assign eoc_o      = (state_q == SEQ_CAL) || (state_q == SEQ_CONV);
   assign eot_o      = (state_q == SEQ_ACQ);
   assign cal_busy_o = (state_q == SEQ_CAL);
   assign step_o     = (state_q == SEQ_CONV) && tick_i;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_BITS    = 12,
   parameter int unsigned CAL_CYCLES  = 58280,
   parameter int unsigned BASE_CYCLES = 49,
   parameter int unsigned ACQ_CYCLES  = 15,
   parameter int unsigned DIV_LOG2    = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic hold_n_i,
   input  logic loop_en_i,
   output logic eoc_o,
   output logic eot_o,
   output logic step_o,
   output logic cal_busy_o
);
   localparam int unsigned CONV_HI  = conv_high_cycles(RES_BITS, BASE_CYCLES);
   localparam int unsigned TICK_DIV = 1 << DIV_LOG2;

   generate
      if (!(RES_BITS == 12 || RES_BITS == 14 || RES_BITS == 16)) begin : g_bad_res
         $error("RES_BITS must be 12, 14 or 16");
      end
      if (CONV_HI % TICK_DIV != 0) begin : g_bad_align
         $error("conversion length must be a whole number of ticks");
      end
      if (CAL_CYCLES < 2 || ACQ_CYCLES < 1 || DIV_LOG2 < 1) begin : g_bad_len
         $error("calibration, acquisition and divider settings out of range");
      end
   endgenerate

   logic tick;
   logic req;
   logic arm;

   adc_seq_tick #(.DIV_LOG2(DIV_LOG2)) u_tick (
      .clk    (clk),
      .rst    (rst),
      .tick_o (tick)
   );

   adc_seq_hold u_hold (
      .clk       (clk),
      .rst       (rst),
      .hold_n_i  (hold_n_i),
      .loop_en_i (loop_en_i),
      .eot_i     (eot_o),
      .arm_i     (arm),
      .tick_i    (tick),
      .req_o     (req)
   );

   adc_seq_fsm #(
      .CAL_CYCLES (CAL_CYCLES),
      .CONV_HI    (CONV_HI),
      .ACQ_CYCLES (ACQ_CYCLES)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .tick_i     (tick),
      .req_i      (req),
      .arm_o      (arm),
      .eoc_o      (eoc_o),
      .eot_o      (eot_o),
      .cal_busy_o (cal_busy_o),
      .step_o     (step_o)
   );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_BITS    = 12,
   parameter int unsigned BASE_CYCLES = 49,
   parameter int unsigned ACQ_CYCLES  = 15
) (
   input logic clk,
   input logic rst,
   input logic eoc,
   input logic eot,
   input logic step,
   input logic cal_busy
);
   localparam int unsigned CONV_HI = conv_high_cycles(RES_BITS, BASE_CYCLES);

   logic [7:0] conv_run;
   logic [7:0] acq_run;
   logic [7:0] step_run;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         conv_run <= '0;
         acq_run  <= '0;
         step_run <= '0;
      end else begin
         conv_run <= (eoc && !cal_busy) ? conv_run + 8'd1 : 8'd0;
         acq_run  <= eot ? acq_run + 8'd1 : 8'd0;
         step_run <= (eoc && !cal_busy) ? step_run + {7'd0, step} : 8'd0;
      end
   end

   AST_RST_FLAGS: assert property (@(posedge clk)
      rst |-> (eoc && cal_busy && !eot && !step)); // R1

   AST_CAL_ENDS_IN_ACQ: assert property (@(posedge clk) disable iff (rst)
      $fell(cal_busy) |-> (eot && !eoc)); // R3

   AST_CONV_LEN: assert property (@(posedge clk) disable iff (rst)
      ($fell(eoc) && !$past(cal_busy)) |-> (conv_run == 8'(CONV_HI))); // R5

   AST_CONV_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
      (eoc && !cal_busy) |-> (conv_run < 8'(CONV_HI))); // R5

   AST_STEP_IN_CONV: assert property (@(posedge clk) disable iff (rst)
      step |-> (eoc && !cal_busy)); // R6

   AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
      step |=> !step); // R6

   AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
      ($fell(eoc) && !$past(cal_busy)) |-> (step_run == 8'(RES_BITS))); // R6

   AST_EOT_AFTER_EOC: assert property (@(posedge clk) disable iff (rst)
      $fell(eoc) |-> eot); // R7

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(eoc && eot)); // R7

   AST_ACQ_LEN: assert property (@(posedge clk) disable iff (rst)
      eot |-> (acq_run < 8'(ACQ_CYCLES))); // R7
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
   .RES_BITS    (RES_BITS),
   .BASE_CYCLES (BASE_CYCLES),
   .ACQ_CYCLES  (ACQ_CYCLES)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .eoc      (eoc_o),
   .eot      (eot_o),
   .step     (step_o),
   .cal_busy (cal_busy_o)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int RES_BITS   = 14;
   localparam int CAL_CYC    = 200;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hold_n = 1'b1;
   logic loop_en = 1'b0;
   logic eoc, eot, step, cal_busy;

   adc_seq_ctrl #(.RES_BITS(RES_BITS), .CAL_CYCLES(CAL_CYC)) u_adc_seq_ctrl (
      .clk        (clk),
      .rst        (rst),
      .hold_n_i   (hold_n),
      .loop_en_i  (loop_en),
      .eoc_o      (eoc),
      .eot_o      (eot),
      .step_o     (step),
      .cal_busy_o (cal_busy)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // master edges since reset release
   int rel;
   always @(posedge clk or posedge rst) begin
      if (rst) rel <= 0;
      else     rel <= rel + 1;
   end

   typedef struct {
      int    cyc;
      int    eoc;
      int    eot;
      int    cal;
      int    stp;
      int    steps;
      string tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   step_tot = 0;

   task automatic cmp(input string tag, input string nm, input int act, input int expv);
      if (expv >= 0) begin
         n_chk++;
         if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (rel cycle %0d)", tag, nm, act, expv, rel);
         end
      end
   endtask

   task automatic expect_at(input int cyc, input int e_eoc, input int e_eot, input int e_cal,
                            input int e_stp, input int e_steps, input string tag);
      exp_t e;
      e.cyc = cyc; e.eoc = e_eoc; e.eot = e_eot; e.cal = e_cal;
      e.stp = e_stp; e.steps = e_steps; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: counts step pulses and pops due expectations
   always @(negedge clk) begin
      if (rst) begin
         step_tot = 0;
      end else begin
         if (step) step_tot++;
         while (sb_q.size() > 0 && sb_q[0].cyc <= rel) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.cyc < rel) begin
               n_chk++; n_fail++;
               $display("FAIL %s missed sample actual=%0d expected=%0d", e.tag, rel, e.cyc);
            end else begin
               cmp(e.tag, "eoc", int'(eoc), e.eoc);
               cmp(e.tag, "eot", int'(eot), e.eot);
               cmp(e.tag, "cal_busy", int'(cal_busy), e.cal);
               cmp(e.tag, "step", int'(step), e.stp);
               cmp(e.tag, "step_total", step_tot, e.steps);
            end
         end
      end
   end

   task automatic wait_rel(input int n);
      while (rel < n) @(negedge clk);
   endtask

   task automatic check_reset_flags(input string tag);
      cmp(tag, "eoc", int'(eoc), 1);
      cmp(tag, "cal_busy", int'(cal_busy), 1);
      cmp(tag, "eot", int'(eot), 0);
      cmp(tag, "step", int'(step), 0);
   endtask

   task automatic drive_all;
      repeat (3) @(negedge clk);
      check_reset_flags("R1 power-on");

      // calibration, hold pulse ignored (R2, R3)
      expect_at(1,   1, 0, 1, -1, 0, "R2 cal start");
      expect_at(61,  1, 0, 1, -1, 0, "R3 hold ignored");
      expect_at(199, 1, 0, 1, -1, 0, "R2 cal last");
      expect_at(200, 0, 1, 0, -1, 0, "R2 cal end");
      expect_at(214, 0, 1, 0, -1, -1, "R7 acq window");
      expect_at(215, 0, 0, 0, -1, -1, "R7 eot fall");
      // async conversion, 4-cycle wait (R4 R5 R6)
      expect_at(303, 0, 0, 0, -1, -1, "R4 wait for tick");
      expect_at(304, 1, 0, 0, -1, -1, "R4 start on tick");
      expect_at(307, 1, 0, 0, 1, -1, "R6 first step");
      expect_at(308, 1, 0, 0, 0, -1, "R6 step single");
      expect_at(359, 1, 0, 0, -1, -1, "R5 conv last");
      expect_at(360, 0, 1, 0, -1, 14, "R5 conv end");
      expect_at(374, 0, 1, 0, -1, -1, "R7 acq window");
      expect_at(375, 0, 0, 0, -1, -1, "R7 eot fall");
      // request one cycle before a tick
      expect_at(403, 0, 0, 0, -1, -1, "R4 short wait");
      expect_at(404, 1, 0, 0, -1, -1, "R4 start");
      expect_at(460, 0, 1, 0, -1, 28, "R6 step count");
      expect_at(475, 0, 0, 0, -1, -1, "R7 eot fall");
      // short pulse between ticks (R8)
      expect_at(503, 0, 0, 0, -1, -1, "R8 before tick");
      expect_at(504, 1, 0, 0, -1, -1, "R8 latched start");
      expect_at(560, 0, 1, 0, -1, 42, "R8 conv end");
      expect_at(575, 0, 0, 0, -1, -1, "R7 eot fall");
      // hold held low: retrigger inside acquisition (R9)
      expect_at(604, 1, 0, 0, -1, -1, "R9 first start");
      expect_at(660, 0, 1, 0, -1, 56, "R9 first end");
      expect_at(663, 0, 1, 0, -1, -1, "R9 in acq");
      expect_at(664, 1, 0, 0, -1, -1, "R9 retrigger");
      expect_at(720, 0, 1, 0, -1, 70, "R9 second end");
      expect_at(735, 0, 0, 0, -1, -1, "R7 eot fall");
      // loopback (R10)
      expect_at(803, 0, 0, 0, -1, -1, "R10 wait");
      expect_at(804, 1, 0, 0, -1, -1, "R10 first");
      expect_at(860, 0, 1, 0, -1, 84, "R10 conv end");
      expect_at(875, 0, 0, 0, -1, -1, "R10 eot fall");
      expect_at(876, 1, 0, 0, -1, -1, "R10 period 72");
      expect_at(947, 0, 0, 0, -1, -1, "R10 before third");
      expect_at(948, 1, 0, 0, -1, -1, "R10 period 72 again");
      expect_at(1004, 0, 1, 0, -1, 112, "R10 last end");
      expect_at(1019, 0, 0, 0, -1, -1, "R7 eot fall");
      expect_at(1104, 1, 0, 0, -1, -1, "R1 conv before reset");
      expect_at(1119, 1, 0, 0, -1, -1, "R1 conv before reset");

      @(negedge clk);
      rst = 1'b0;

      wait_rel(50);  hold_n = 1'b0;
      wait_rel(58);  hold_n = 1'b1;
      wait_rel(300); hold_n = 1'b0;
      wait_rel(310); hold_n = 1'b1;
      wait_rel(403); hold_n = 1'b0;
      wait_rel(410); hold_n = 1'b1;
      wait_rel(501); hold_n = 1'b0;
      wait_rel(502); hold_n = 1'b1;
      wait_rel(601); hold_n = 1'b0;
      wait_rel(670); hold_n = 1'b1;
      wait_rel(800); loop_en = 1'b1;
      wait_rel(950); loop_en = 1'b0;
      wait_rel(1101); hold_n = 1'b0;
      wait_rel(1110); hold_n = 1'b1;
      wait_rel(1120);

      // reset in mid-conversion (R1), then fresh calibration (R2)
      rst = 1'b1;
      @(negedge clk);
      check_reset_flags("R1 mid-conversion");
      @(negedge clk);
      check_reset_flags("R1 held");
      expect_at(199, 1, 0, 1, -1, 0, "R2 recal last");
      expect_at(200, 0, 1, 0, -1, 0, "R2 recal end");
      expect_at(215, 0, 0, 0, -1, -1, "R7 eot fall");
      expect_at(304, 1, 0, 0, -1, -1, "R4 start after recal");
      expect_at(360, 0, 1, 0, -1, 14, "R5 conv end after recal");
      rst = 1'b0;
      wait_rel(300); hold_n = 1'b0;
      wait_rel(310); hold_n = 1'b1;
      wait_rel(400);
   endtask

   initial begin
      fork
         drive_all();
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
         end
      join_any
      disable fork;
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_chk++; n_fail++;
         $display("FAIL %s unchecked actual=none expected=cycle %0d", e.tag, e.cyc);
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule